// File: doc/BRIEF.md
# Cross-Domain Call Sequencer

This block sits beside a small processor's fetch decoder and enforces entry and exit between protection domains that share one data RAM. When the decoder reports a call whose target lies inside a configurable jump-table window, the block switches the active domain to the callee's domain. The callee's domain ID is supplied by an external lookup. The block also sets a new run-time stack bound equal to the current stack pointer, and saves a five-byte call frame on a protected safe stack in data RAM. The processor is stalled while the frame is written.

When the decoder reports a cross-domain return, the block reads the top frame back in reverse order. It compares the saved return address with the address being returned to. If they match, it restores the caller's domain and stack bound and releases the frame. If they differ, it raises panic and leaves the frame and all state as they were. A call that would push the safe stack past its configured limit raises panic, and so does a return when no frame is held. In both cases the call or return has no other effect.

Four configuration registers can be written only while the trusted domain is active: the jump-table window bounds, the safe-stack base and the safe-stack limit. The safe stack grows toward higher addresses.

Top module: `domain_call_unit`

## Requirements
- R1: After reset, cur_dom equals the trusted domain ID (0 by default), stack_bound is 0, ss_ptr is 0, and stall, panic, ram_we and ram_re are all 0.
- R2: A cfg_we write is accepted only while cur_dom is the trusted domain; otherwise it has no effect. cfg_sel selects the register: 0 = jump-table low (inclusive), 1 = jump-table high (exclusive), 2 = safe-stack base (also loads ss_ptr one cycle after the write), 3 = safe-stack limit (exclusive).
- R3: A call strobe is a cross-domain call only when low ≤ call_target < high. Any other call leaves stall, panic, RAM strobes, ss_ptr and cur_dom unchanged.
- R4: An accepted call writes five bytes on five consecutive cycles, starting one cycle after the accepting edge, to ss_ptr+0 through ss_ptr+4. The byte order is return address low, return address high, old stack bound low, old stack bound high, old domain ID zero-extended to 8 bits. ss_ptr then reads ss_ptr+5.
- R5: On the accepting edge of a call, cur_dom becomes callee_dom and stack_bound becomes stack_ptr. Both stay stable while RAM strobes are active.
- R6: stall is high from the accepting edge through the cycle of the last frame access, and it covers every RAM access the block makes.
- R7: An accepted return reads ss_ptr-1 down to ss_ptr-5 on five consecutive cycles. Seven cycles after the accepting edge, if the saved return address equals ret_addr, cur_dom and stack_bound take the saved values and ss_ptr drops by 5.
- R8: If the saved return address differs from ret_addr, panic pulses for one cycle seven cycles after acceptance, and cur_dom, stack_bound and ss_ptr are left unchanged.
- R9: A qualifying call for which ss_ptr+5 exceeds the safe-stack limit pulses panic one cycle after the strobe, writes nothing, does not stall, and leaves cur_dom unchanged.
- R10: A return while ss_ptr < base+5 pulses panic one cycle after the strobe and performs no read.
- R11: Chained calls nest: returns restore domains and bounds in last-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write value |
| call_strobe | input | 1 | Decoder reports a call |
| call_target | input | ADDR_W | Call target address |
| ret_strobe | input | 1 | Decoder reports a cross-domain return |
| ret_addr | input | ADDR_W | Return address (saved on call, checked on return) |
| callee_dom | input | DOM_W | Callee domain from the lookup |
| stack_ptr | input | SB_W | Current run-time stack pointer |
| ram_rdata | input | 8 | RAM read data, one cycle after ram_re |
| cur_dom | output | DOM_W | Active domain ID |
| stack_bound | output | SB_W | Active run-time stack bound |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_addr | output | RAM_AW | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ss_ptr | output | RAM_AW | Safe-stack pointer (next free byte) |
| stall | output | 1 | Processor stall |
| panic | output | 1 | One-cycle fault pulse |

## Verification
The bench applies each strobe for one cycle and numbers edges from the accepting edge E0. The domain, bound and stall change are sampled just after E0. Frame bytes are due one per cycle just after E1 through E5, and the advanced pointer and released stall are checked after E6. For a return, read addresses are due after E1 through E5, because the RAM model returns data one cycle after each read. The restore or the panic pulse is therefore due after E7, and stall is checked high after E6 and low after E7. Every sample is taken on the falling edge at exactly those offsets, so a result that arrives one cycle early or late is reported.

// File: rtl/dcu_pkg.sv
package dcu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_POP  = 2'd2
  } dcu_state_e;

  localparam logic [1:0] SEL_JT_LO = 2'd0;
  localparam logic [1:0] SEL_JT_HI = 2'd1;
  localparam logic [1:0] SEL_SS_BASE = 2'd2;
  localparam logic [1:0] SEL_SS_LIM = 2'd3;
endpackage

// File: rtl/dcu_window.sv
module dcu_window #(
  parameter int W = 16
) (
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] addr,
  output logic         hit
);
  always_comb hit = (addr >= lo) && (addr < hi);
endmodule

// File: rtl/dcu_cfg.sv
module dcu_cfg #(
  parameter int ADDR_W    = 16,
  parameter int DOM_W     = 3,
  parameter int TRUST_DOM = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [DOM_W-1:0]  cur_dom,
  output logic [ADDR_W-1:0] jt_lo,
  output logic [ADDR_W-1:0] jt_hi,
  output logic [ADDR_W-1:0] ss_base,
  output logic [ADDR_W-1:0] ss_limit,
  output logic              ss_load
);
  import dcu_pkg::*;

  logic trusted;
  always_comb trusted = (cur_dom == DOM_W'(TRUST_DOM));

  always_ff @(posedge clk) begin
    if (rst) begin
      jt_lo    <= '0;
      jt_hi    <= '0;
      ss_base  <= '0;
      ss_limit <= '0;
      ss_load  <= 1'b0;
    end else begin
      ss_load <= 1'b0;
      if (cfg_we && trusted) begin
        case (cfg_sel)
          SEL_JT_LO:   jt_lo <= cfg_wdata;
          SEL_JT_HI:   jt_hi <= cfg_wdata;
          SEL_SS_BASE: begin
            ss_base <= cfg_wdata;
            ss_load <= 1'b1;
          end
          default:     ss_limit <= cfg_wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/dcu_seq.sv
module dcu_seq #(
  parameter int ADDR_W    = 16,
  parameter int SB_W      = 16,
  parameter int DOM_W     = 3,
  parameter int RAM_AW    = 10,
  parameter int TRUST_DOM = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              call_hit,
  input  logic              ret_strobe,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [DOM_W-1:0]  callee_dom,
  input  logic [SB_W-1:0]   stack_ptr,
  input  logic [ADDR_W-1:0] ss_base,
  input  logic [ADDR_W-1:0] ss_limit,
  input  logic              ss_load,
  input  logic [7:0]        ram_rdata,
  output logic [DOM_W-1:0]  cur_dom,
  output logic [SB_W-1:0]   stack_bound,
  output logic              ram_we,
  output logic              ram_re,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic [RAM_AW-1:0] ss_ptr,
  output logic              stall,
  output logic              panic
);
  import dcu_pkg::*;

  localparam int RET_BYTES   = ADDR_W / 8;
  localparam int SB_BYTES    = SB_W / 8;
  localparam int FRAME_BYTES = RET_BYTES + SB_BYTES + 1;
  localparam int FRAME_W     = FRAME_BYTES * 8;
  localparam int CNT_W       = $clog2(FRAME_BYTES + 2);
  localparam int PW          = ADDR_W + 1;
  localparam int FIRST_CAP   = 2;
  localparam logic [CNT_W-1:0] LAST_PUSH = CNT_W'(FRAME_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_POP  = CNT_W'(FRAME_BYTES + 1);

  dcu_state_e          state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [FRAME_W-1:0]  frame_q;
  logic [FRAME_W-9:0]  pop_q;
  logic [FRAME_W-1:0]  cand;
  logic [ADDR_W-1:0]   ret_q;
  logic [PW-1:0]       ptr_ext;
  logic                ovf;
  logic                empty;
  logic                frame_ok;
  logic                stall_n;

  always_comb begin
    ptr_ext  = PW'(ss_ptr);
    ovf      = (ptr_ext + PW'(FRAME_BYTES)) > {1'b0, ss_limit};
    empty    = ptr_ext < ({1'b0, ss_base} + PW'(FRAME_BYTES));
    cand     = {pop_q, ram_rdata};
    frame_ok = (cand[ADDR_W-1:0] == ret_q) &&
               (cand[FRAME_W-1 -: (8 - DOM_W)] == '0);
  end

  always_comb begin
    case (state_q)
      ST_IDLE: stall_n = (call_hit && !ovf) || (!call_hit && ret_strobe && !empty);
      ST_PUSH: stall_n = 1'b1;
      ST_POP:  stall_n = (cnt_q != LAST_POP);
      default: stall_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      frame_q     <= '0;
      pop_q       <= '0;
      ret_q       <= '0;
      cur_dom     <= DOM_W'(TRUST_DOM);
      stack_bound <= '0;
      ram_we      <= 1'b0;
      ram_re      <= 1'b0;
      ram_addr    <= '0;
      ram_wdata   <= '0;
      ss_ptr      <= '0;
      stall       <= 1'b0;
      panic       <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      ram_re <= 1'b0;
      panic  <= 1'b0;
      stall  <= stall_n;
      case (state_q)
        ST_IDLE: begin
          if (ss_load) ss_ptr <= ss_base[RAM_AW-1:0];
          if (call_hit) begin
            if (ovf) begin
              panic <= 1'b1;
            end else begin
              frame_q     <= {{(8 - DOM_W){1'b0}}, cur_dom, stack_bound, ret_addr};
              cur_dom     <= callee_dom;
              stack_bound <= stack_ptr;
              cnt_q       <= '0;
              state_q     <= ST_PUSH;
            end
          end else if (ret_strobe) begin
            if (empty) begin
              panic <= 1'b1;
            end else begin
              ret_q   <= ret_addr;
              cnt_q   <= '0;
              state_q <= ST_POP;
            end
          end
        end
        ST_PUSH: begin
          ram_we    <= 1'b1;
          ram_addr  <= ss_ptr + RAM_AW'(cnt_q);
          ram_wdata <= frame_q[int'(cnt_q) * 8 +: 8];
          cnt_q     <= cnt_q + 1'b1;
          if (cnt_q == LAST_PUSH) begin
            ss_ptr  <= ss_ptr + RAM_AW'(FRAME_BYTES);
            state_q <= ST_IDLE;
          end
        end
        ST_POP: begin
          if (int'(cnt_q) < FRAME_BYTES) begin
            ram_re   <= 1'b1;
            ram_addr <= ss_ptr - RAM_AW'(cnt_q) - RAM_AW'(1);
          end
          if (int'(cnt_q) >= FIRST_CAP) pop_q <= cand[FRAME_W-9:0];
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_POP) begin
            if (frame_ok) begin
              cur_dom     <= cand[FRAME_W-8 +: DOM_W];
              stack_bound <= cand[ADDR_W +: SB_W];
              ss_ptr      <= ss_ptr - RAM_AW'(FRAME_BYTES);
            end else begin
              panic <= 1'b1;
            end
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/domain_call_unit.sv
module domain_call_unit #(
  parameter int ADDR_W    = 16,
  parameter int SB_W      = 16,
  parameter int DOM_W     = 3,
  parameter int RAM_AW    = 10,
  parameter int TRUST_DOM = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              call_strobe,
  input  logic [ADDR_W-1:0] call_target,
  input  logic              ret_strobe,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [DOM_W-1:0]  callee_dom,
  input  logic [SB_W-1:0]   stack_ptr,
  input  logic [7:0]        ram_rdata,
  output logic [DOM_W-1:0]  cur_dom,
  output logic [SB_W-1:0]   stack_bound,
  output logic              ram_we,
  output logic              ram_re,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic [RAM_AW-1:0] ss_ptr,
  output logic              stall,
  output logic              panic
);
  logic [ADDR_W-1:0] jt_lo, jt_hi, ss_base, ss_limit;
  logic              ss_load;
  logic              win_hit;
  logic              call_hit;

  dcu_cfg #(.ADDR_W(ADDR_W), .DOM_W(DOM_W), .TRUST_DOM(TRUST_DOM)) i_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cur_dom(cur_dom), .jt_lo(jt_lo), .jt_hi(jt_hi),
    .ss_base(ss_base), .ss_limit(ss_limit), .ss_load(ss_load)
  );

  dcu_window #(.W(ADDR_W)) i_win (
    .lo(jt_lo), .hi(jt_hi), .addr(call_target), .hit(win_hit)
  );

  always_comb call_hit = call_strobe && win_hit;

  dcu_seq #(
    .ADDR_W(ADDR_W), .SB_W(SB_W), .DOM_W(DOM_W),
    .RAM_AW(RAM_AW), .TRUST_DOM(TRUST_DOM)
  ) i_seq (
    .clk(clk), .rst(rst), .call_hit(call_hit), .ret_strobe(ret_strobe),
    .ret_addr(ret_addr), .callee_dom(callee_dom), .stack_ptr(stack_ptr),
    .ss_base(ss_base), .ss_limit(ss_limit), .ss_load(ss_load),
    .ram_rdata(ram_rdata), .cur_dom(cur_dom), .stack_bound(stack_bound),
    .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ss_ptr(ss_ptr), .stall(stall), .panic(panic)
  );
endmodule

// File: rtl/dcu_props.sv
module dcu_props #(
  parameter int SB_W   = 16,
  parameter int DOM_W  = 3,
  parameter int RAM_AW = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [DOM_W-1:0]  cur_dom,
  input logic [SB_W-1:0]   stack_bound,
  input logic              ram_we,
  input logic              ram_re,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              stall,
  input logic              panic
);
  p_rw_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re));

  p_access_stalled_r6: assert property (@(posedge clk) disable iff (rst)
    (ram_we || ram_re) |-> stall);

  p_push_ascends_r4: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |-> (ram_addr == RAM_AW'($past(ram_addr) + 1'b1)));

  p_pop_descends_r7: assert property (@(posedge clk) disable iff (rst)
    (ram_re && $past(ram_re)) |-> (ram_addr == RAM_AW'($past(ram_addr) - 1'b1)));

  p_dom_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ram_we || ram_re) |-> ($stable(cur_dom) && $stable(stack_bound)));

  p_panic_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    panic |-> (!ram_we && !ram_re));
endmodule

bind domain_call_unit dcu_props #(.SB_W(SB_W), .DOM_W(DOM_W), .RAM_AW(RAM_AW)) i_props (
  .clk(clk), .rst(rst), .cur_dom(cur_dom), .stack_bound(stack_bound),
  .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
  .stall(stall), .panic(panic)
);

// File: tb/test_domain_call_unit.sv
module test_domain_call_unit;
  localparam int ADDR_W = 16, SB_W = 16, DOM_W = 3, RAM_AW = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [ADDR_W-1:0] cfg_wdata = '0, call_target = '0, ret_addr = '0;
  logic call_strobe = 1'b0, ret_strobe = 1'b0;
  logic [DOM_W-1:0] callee_dom = '0;
  logic [SB_W-1:0] stack_ptr = '0;
  logic [7:0] ram_rdata;
  logic [DOM_W-1:0] cur_dom;
  logic [SB_W-1:0] stack_bound;
  logic ram_we, ram_re, stall, panic;
  logic [RAM_AW-1:0] ram_addr, ss_ptr;
  logic [7:0] ram_wdata;

  always #5 clk = ~clk;

  domain_call_unit i_domain_call_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .call_strobe(call_strobe), .call_target(call_target), .ret_strobe(ret_strobe),
    .ret_addr(ret_addr), .callee_dom(callee_dom), .stack_ptr(stack_ptr),
    .ram_rdata(ram_rdata), .cur_dom(cur_dom), .stack_bound(stack_bound),
    .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ss_ptr(ss_ptr), .stall(stall), .panic(panic)
  );

  logic [7:0] mem [0:(1<<RAM_AW)-1];
  initial begin
    for (int i = 0; i < (1 << RAM_AW); i++) mem[i] = 8'h00;
    ram_rdata = 8'h00;
  end
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_lo = 0, m_hi = 0, m_base = 0, m_lim = 0, m_ptr = 0, m_bound = 0;
  logic [2:0] m_dom = 0;
  logic [15:0] s_ret [0:15];
  logic [15:0] s_bnd [0:15];
  logic [2:0]  s_dom [0:15];
  int depth = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    tick();
    cfg_we = 1'b0;
    tick();
    if (m_dom == 3'd0) begin
      case (sel)
        2'd0: m_lo = val;
        2'd1: m_hi = val;
        2'd2: begin m_base = val; m_ptr = val; end
        default: m_lim = val;
      endcase
    end
  endtask

  task automatic do_call(input logic [15:0] tgt, input logic [15:0] ra,
                         input logic [2:0] d, input logic [15:0] sp);
    bit hit, ovf;
    logic [7:0] b [0:4];
    hit = (tgt >= m_lo) && (tgt < m_hi);
    ovf = (32'(m_ptr) + 5) > 32'(m_lim);
    call_target = tgt; ret_addr = ra; callee_dom = d; stack_ptr = sp;
    call_strobe = 1'b1;
    tick();
    call_strobe = 1'b0;
    if (!hit) begin
      chk("R3 stall on non-qualifying call", stall, 0);
      chk("R3 panic on non-qualifying call", panic, 0);
      for (int i = 0; i < 6; i++) begin
        tick();
        chk("R3 no write", ram_we, 0);
      end
      chk("R3 ss_ptr unchanged", ss_ptr, m_ptr);
      chk("R3 domain unchanged", cur_dom, m_dom);
    end else if (ovf) begin
      chk("R9 overflow panic", panic, 1);
      chk("R9 no stall", stall, 0);
      chk("R9 no write", ram_we, 0);
      tick();
      chk("R9 panic is a pulse", panic, 0);
      chk("R9 no write later", ram_we, 0);
      chk("R9 ss_ptr unchanged", ss_ptr, m_ptr);
      chk("R9 domain unchanged", cur_dom, m_dom);
    end else begin
      b[0] = ra[7:0]; b[1] = ra[15:8];
      b[2] = m_bound[7:0]; b[3] = m_bound[15:8]; b[4] = {5'd0, m_dom};
      chk("R6 stall at accept", stall, 1);
      chk("R5 new domain", cur_dom, d);
      chk("R5 new stack bound", stack_bound, sp);
      for (int i = 0; i < 5; i++) begin
        tick();
        chk("R4 write strobe", ram_we, 1);
        chk("R4 write address", ram_addr, m_ptr + 16'(i));
        chk("R4 frame byte", ram_wdata, b[i]);
        chk("R6 stall during push", stall, 1);
      end
      tick();
      chk("R6 stall released", stall, 0);
      chk("R4 write ended", ram_we, 0);
      chk("R4 ss_ptr advanced", ss_ptr, m_ptr + 5);
      s_ret[depth] = ra; s_bnd[depth] = m_bound; s_dom[depth] = m_dom;
      depth++;
      m_ptr = m_ptr + 5; m_dom = d; m_bound = sp;
    end
  endtask

  task automatic do_ret(input logic [15:0] ra);
    bit emp, match;
    emp = (32'(m_ptr) < 32'(m_base) + 5);
    ret_addr = ra;
    ret_strobe = 1'b1;
    tick();
    ret_strobe = 1'b0;
    if (emp) begin
      chk("R10 empty return panic", panic, 1);
      chk("R10 no stall", stall, 0);
      tick();
      chk("R10 no read", ram_re, 0);
      chk("R10 ss_ptr unchanged", ss_ptr, m_ptr);
    end else begin
      match = (ra == s_ret[depth-1]);
      chk("R6 stall at return accept", stall, 1);
      for (int i = 0; i < 5; i++) begin
        tick();
        chk("R7 read strobe", ram_re, 1);
        chk("R7 read address", ram_addr, m_ptr - 16'(1 + i));
      end
      tick();
      chk("R6 stall before decision", stall, 1);
      chk("R7 no early panic", panic, 0);
      tick();
      chk("R6 stall released after return", stall, 0);
      if (match) begin
        depth--;
        m_ptr = m_ptr - 5; m_dom = s_dom[depth]; m_bound = s_bnd[depth];
        chk("R7 no panic on match", panic, 0);
        chk("R11 domain restored", cur_dom, m_dom);
        chk("R11 bound restored", stack_bound, m_bound);
        chk("R7 ss_ptr released", ss_ptr, m_ptr);
      end else begin
        chk("R8 mismatch panic", panic, 1);
        chk("R8 domain kept", cur_dom, m_dom);
        chk("R8 bound kept", stack_bound, m_bound);
        chk("R8 ss_ptr kept", ss_ptr, m_ptr);
        tick();
        chk("R8 panic is a pulse", panic, 0);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] tg;
    repeat (3) tick();
    chk("R1 reset domain", cur_dom, 0);
    chk("R1 reset bound", stack_bound, 0);
    chk("R1 reset ss_ptr", ss_ptr, 0);
    chk("R1 reset stall", stall, 0);
    chk("R1 reset panic", panic, 0);
    chk("R1 reset write", ram_we, 0);
    chk("R1 reset read", ram_re, 0);
    rst = 1'b0;
    tick();

    cfg_write(2'd0, 16'h0100);
    cfg_write(2'd1, 16'h0140);
    cfg_write(2'd2, 16'h0040);
    cfg_write(2'd3, 16'h0068);
    chk("R2 trusted base write loads ss_ptr", ss_ptr, 16'h0040);

    // R3 sweep around both window edges
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: tg = 16'h00FF;
        1: tg = 16'h0100;
        2: tg = 16'h013F;
        3: tg = 16'h0140;
        4: tg = 16'h0000;
        default: tg = 16'hFFFF;
      endcase
      do_call(tg, 16'h2000 + 16'(k), 3'(1 + k % 7), 16'h0300 - 16'(k * 16));
      if (depth > 0) do_ret(16'h2000 + 16'(k));
    end

    // R11 chained calls over every domain ID, filling the stack exactly
    for (int d = 1; d <= 8; d++)
      do_call(16'h0120, 16'h3000 + 16'(d * 3), 3'(d % 8), 16'h0400 - 16'(d * 32));
    do_call(16'h0121, 16'h5555, 3'd4, 16'h0111);   // R9 overflow
    do_ret(16'hDEAD);                               // R8 mismatch
    for (int d = 8; d >= 1; d--) do_ret(16'h3000 + 16'(d * 3));
    do_ret(16'h1234);                               // R10 empty

    // R2 writes from an untrusted domain are ignored
    do_call(16'h0110, 16'h4000, 3'd5, 16'h0500);
    cfg_write(2'd1, 16'hFFFF);
    cfg_write(2'd2, 16'h0010);
    chk("R2 untrusted base write ignored", ss_ptr, m_ptr);
    do_call(16'h0150, 16'h4010, 3'd6, 16'h0510);
    do_ret(16'h4000);
    cfg_write(2'd1, 16'h0160);
    do_call(16'h0150, 16'h4100, 3'd2, 16'h0600);
    chk("R2 trusted bound write took effect", cur_dom, 2);
    do_ret(16'h4100);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule